// File: doc/BRIEF.md
# Dual-Mode Serial Register Access Slave

This block lets an external master read and write a 128-location space of timekeeping registers and user RAM over a serial link. It does so through an internal port to the register file. A static mode pin selects the link type. With the pin high, the link is a four-wire SPI with separate data input and output. With the pin low, it is a three-wire link whose single data line is formed by tying the data input to the driven output. All serial inputs are brought into the system clock domain through synchronizers, and all work is done on detected serial clock edges.

Every transaction opens with chip enable rising. The first byte is an address. Its top bit chooses the direction (1 writes, 0 reads) and its low seven bits give the location. Any number of data bytes follow, and the location steps after each byte. It wraps inside a clock window (00h..1Fh) or a RAM window (20h..7Fh). Locations 12h..1Fh are reserved. The control byte at location 0Fh lives inside this block, because its bit 6 gates every write. The rest of the control byte is offered to neighbouring logic on `ctrl_o`.

The register port is strobe based. `reg_rd` asks for `reg_rdata` at `reg_addr`, and the block samples the data on the second rising clock edge after the strobe. `reg_wr` writes `reg_wdata` to `reg_addr` in one cycle.

Top module: `rsa_slave`

## Requirements
- R1: After reset, `sdo_oe`, `reg_rd` and `reg_wr` are 0 and `ctrl_o` is 00h.
- R2: The first byte after chip enable rises is the address. If its bit 7 is 1, each following byte is written through the port (`reg_wr`, `reg_addr` = address bits 6:0, `reg_wdata` = byte). If bit 7 is 0, the following bytes are read.
- R3: In SPI mode, the level of the serial clock when chip enable rises is taken as its idle level. Input bits are captured on edges that return the clock to that level, and output bits change on edges that leave it. Bytes travel most significant bit first.
- R4: In three-wire mode, bytes travel least significant bit first. Input is captured on serial clock rising and output changes on serial clock falling, all on the one shared line.
- R5: `sdo_oe` stays 0 through the address byte and while chip enable is low. It rises only at the first output-shifting edge of a read's first data byte.
- R6: A read burst steps the location after each byte, wrapping 1Fh to 00h and 7Fh to 20h.
- R7: A write burst steps the location after each byte, wrapping address 9Fh to 80h and FFh to A0h.
- R8: Reads of locations 12h..1Fh return 00h without a port read. Writes to them cause no port write.
- R9: Location 0Fh is the control byte, held in the block and shown on `ctrl_o`. Its bits 5:3 always read 0, and reads of 0Fh return it.
- R10: While control bit 6 is 1, no port write occurs and control bits 7 and 2:0 keep their value. Bit 6 itself still takes the written value.
- R11: Each read data byte after the first is fetched while the previous byte shifts out, so a burst read delivers back-to-back bytes with no idle bit times.
- R12: Chip enable falling mid-byte ends the transaction. A partial write byte causes no write, and the next transaction starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_mode | input | 1 | 1 = SPI link, 0 = three-wire link |
| ce | input | 1 | Chip enable from the master |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data input (tied to `sdo` in three-wire mode) |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| reg_addr | output | 7 | Register port location |
| reg_rd | output | 1 | Register port read strobe |
| reg_wr | output | 1 | Register port write strobe |
| reg_wdata | output | 8 | Register port write data |
| reg_rdata | input | 8 | Register port read data, valid the cycle after `reg_rd` |
| ctrl_o | output | 8 | Current control byte |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and holds each serial clock phase for 12 system clocks. The deeper synchronizer adds input latency, and the short phases leave the address decode, the port read and the output load only a few spare cycles before the first output bit is needed. This tests the prefetch timing that gapless burst reads rely on. Both SPI idle levels and the three-wire line are run across both wrap points, the reserved range, the write-protect sequence and a mid-byte abort.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int BYTE_W = 8;
  localparam int LOC_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LOC_W-1:0]  loc_t;

  // location map: behaviour depends on these values
  localparam loc_t  CTRL_LOC  = 7'h0F;
  localparam loc_t  RSV_LO    = 7'h12;
  localparam loc_t  CLK_TOP   = 7'h1F;
  localparam loc_t  RAM_BASE  = 7'h20;
  localparam loc_t  RAM_TOP   = 7'h7F;
  localparam int    WP_POS    = 6;
  localparam byte_t CTRL_MASK = 8'hC7;

  typedef enum logic [1:0] {SRC_PORT, SRC_CTRL, SRC_ZERO} src_e;

  // location that follows l inside its own window
  function automatic loc_t next_loc(loc_t l);
    if (l == CLK_TOP)      return '0;
    else if (l == RAM_TOP) return RAM_BASE;
    else                   return l + 1'b1;
  endfunction

  function automatic src_e loc_src(loc_t l);
    if (l >= RSV_LO && l <= CLK_TOP) return SRC_ZERO;
    else if (l == CTRL_LOC)          return SRC_CTRL;
    else                             return SRC_PORT;
  endfunction

  function automatic byte_t shift_in(byte_t sr, logic b, logic msb_first);
    return msb_first ? {sr[BYTE_W-2:0], b} : {b, sr[BYTE_W-1:1]};
  endfunction

  function automatic logic out_bit(byte_t sr, logic msb_first);
    return msb_first ? sr[BYTE_W-1] : sr[0];
  endfunction

  function automatic byte_t shift_out(byte_t sr, logic msb_first);
    return msb_first ? {sr[BYTE_W-2:0], 1'b0} : {1'b0, sr[BYTE_W-1:1]};
  endfunction

  // control update: with protection on only the protect bit moves
  function automatic byte_t ctrl_merge(byte_t old, byte_t wr, logic wp);
    byte_t r;
    if (wp) begin
      r = old;
      r[WP_POS] = wr[WP_POS];
    end else begin
      r = wr & CTRL_MASK;
    end
    return r;
  endfunction
endpackage

// File: rtl/rsa_sync.sv
module rsa_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rsa_shift.sv
module rsa_shift
  import rsa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  spi_mode,
  input  logic  ce_s,
  input  logic  sclk_s,
  input  logic  sdi_s,
  input  logic  tx_active,
  input  byte_t tx_byte,
  output logic  rx_done,
  output byte_t rx_byte,
  output logic  tx_take,
  output logic  sdo,
  output logic  sdo_oe
);
  logic ce_d, sclk_d, pol_q;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  byte_t rx_sr, tx_sr, rx_next;
  logic clk_edge, strobe_evt, shift_evt, msb_first;

  assign msb_first  = spi_mode;
  assign clk_edge   = ce_s & ce_d & (sclk_s ^ sclk_d);
  assign strobe_evt = clk_edge & (sclk_s == pol_q);
  assign shift_evt  = clk_edge & (sclk_s != pol_q);
  assign rx_next    = shift_in(rx_sr, sdi_s, msb_first);
  assign tx_take    = shift_evt & tx_active & (tx_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d <= 1'b0; sclk_d <= 1'b0; pol_q <= 1'b0;
      rx_cnt <= '0; tx_cnt <= '0; rx_sr <= '0; tx_sr <= '0;
      rx_done <= 1'b0; rx_byte <= '0; sdo <= 1'b0; sdo_oe <= 1'b0;
    end else begin
      ce_d    <= ce_s;
      sclk_d  <= sclk_s;
      rx_done <= 1'b0;
      if (ce_s && !ce_d) pol_q <= spi_mode ? sclk_s : 1'b1;
      if (!ce_s) begin
        rx_cnt <= '0;
        tx_cnt <= '0;
        sdo_oe <= 1'b0;
      end else begin
        if (strobe_evt) begin
          rx_sr  <= rx_next;
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == CNT_W'(BYTE_W - 1)) begin
            rx_done <= 1'b1;
            rx_byte <= rx_next;
          end
        end
        if (shift_evt && tx_active) begin
          sdo_oe <= 1'b1;
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == '0) begin
            sdo   <= out_bit(tx_byte, msb_first);
            tx_sr <= shift_out(tx_byte, msb_first);
          end else begin
            sdo   <= out_bit(tx_sr, msb_first);
            tx_sr <= shift_out(tx_sr, msb_first);
          end
        end
      end
    end
  end

  // R5
  oe_rise_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(shift_evt));

  // R3
  edge_kinds_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(strobe_evt) && !$past(shift_evt));
endmodule

// File: rtl/rsa_seq.sv
module rsa_seq
  import rsa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_s,
  input  logic  rx_done,
  input  byte_t rx_byte,
  input  logic  tx_take,
  output logic  tx_active,
  output byte_t tx_byte,
  output loc_t  reg_addr,
  output logic  reg_rd,
  output logic  reg_wr,
  output byte_t reg_wdata,
  input  byte_t reg_rdata,
  output byte_t ctrl_q
);
  logic in_data, is_wr;
  loc_t loc, fetch_loc;
  logic fetch_req, wr_req, addr_byte;
  logic [1:0] pend;
  src_e pend_src;

  assign addr_byte = ce_s & rx_done & ~in_data;
  assign wr_req    = ce_s & rx_done & in_data & is_wr;
  assign tx_active = in_data & ~is_wr;

  always_comb begin
    fetch_req = 1'b0;
    fetch_loc = loc;
    if (addr_byte && !rx_byte[BYTE_W-1]) begin
      fetch_req = 1'b1;
      fetch_loc = rx_byte[LOC_W-1:0];
    end else if (ce_s && tx_take) begin
      fetch_req = 1'b1;
      fetch_loc = next_loc(loc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= 1'b0; is_wr <= 1'b0; loc <= '0; pend <= '0;
      pend_src <= SRC_PORT; tx_byte <= '0; reg_addr <= '0;
      reg_rd <= 1'b0; reg_wr <= 1'b0; reg_wdata <= '0; ctrl_q <= '0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      pend   <= {pend[0], fetch_req};
      if (!ce_s) begin
        in_data <= 1'b0;
        is_wr   <= 1'b0;
      end else if (addr_byte) begin
        in_data <= 1'b1;
        is_wr   <= rx_byte[BYTE_W-1];
        loc     <= rx_byte[LOC_W-1:0];
      end else if (wr_req) begin
        loc <= next_loc(loc);
        case (loc_src(loc))
          SRC_CTRL: ctrl_q <= ctrl_merge(ctrl_q, rx_byte, ctrl_q[WP_POS]);
          SRC_PORT: if (!ctrl_q[WP_POS]) begin
            reg_wr    <= 1'b1;
            reg_addr  <= loc;
            reg_wdata <= rx_byte;
          end
          default: ;
        endcase
      end else if (tx_take) begin
        loc <= next_loc(loc);
      end
      if (fetch_req) begin
        pend_src <= loc_src(fetch_loc);
        if (loc_src(fetch_loc) == SRC_PORT) begin
          reg_rd   <= 1'b1;
          reg_addr <= fetch_loc;
        end
      end
      if (pend[1]) begin
        case (pend_src)
          SRC_CTRL: tx_byte <= ctrl_q;
          SRC_ZERO: tx_byte <= '0;
          default:  tx_byte <= reg_rdata;
        endcase
      end
    end
  end

  // R10
  wp_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(ctrl_q[WP_POS]));

  // R8
  no_rsv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> loc_src(reg_addr) == SRC_PORT);

  // R8
  no_rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> loc_src(reg_addr) == SRC_PORT);

  // R11
  prefetch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> pend == 2'b00);

  // R9
  ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);

  // R2
  port_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
endmodule

// File: rtl/rsa_slave.sv
module rsa_slave
  import rsa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_mode,
  input  logic       ce,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic [6:0] reg_addr,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  output logic [7:0] ctrl_o
);
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] pins_s;
  logic ce_s, sclk_s, sdi_s;
  logic rx_done, tx_take, tx_active;
  byte_t rx_byte, tx_byte;

  rsa_sync #(.STAGES(SYNC_STAGES), .W(N_SYNC)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({ce, sclk, sdi}), .q(pins_s));

  assign {ce_s, sclk_s, sdi_s} = pins_s;

  rsa_shift i_shift (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .ce_s(ce_s),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .tx_active(tx_active),
    .tx_byte(tx_byte), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_take(tx_take), .sdo(sdo), .sdo_oe(sdo_oe));

  rsa_seq i_seq (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .rx_done(rx_done),
    .rx_byte(rx_byte), .tx_take(tx_take), .tx_active(tx_active),
    .tx_byte(tx_byte), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl_q(ctrl_o));

  // R5
  oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdo_oe);

  // R12
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !reg_wr);
endmodule

// File: tb/test_rsa_slave.sv
module test_rsa_slave;
  localparam int H = 12;

  logic clk = 0, rst_n = 0, spi_mode = 1, ce = 0, sclk = 0, mosi = 0;
  logic sdo, sdo_oe, reg_rd, reg_wr;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, ctrl_o;
  logic sdi_w;

  int n_chk = 0, n_fail = 0, wr_seen = 0;
  logic cur_spi, cur_cpol;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] exp_ctrl = 8'h00;
  logic [7:0] exp_rd_q [$];
  string      exp_tag_q [$];
  logic [7:0] got_q [$];
  logic [14:0] exp_wr_q [$];
  bit finished = 0;

  always #2 clk = ~clk;

  assign sdi_w = (!spi_mode && sdo_oe) ? sdo : mosi;

  rsa_slave #(.SYNC_STAGES(3)) i_rsa_slave (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .ce(ce), .sclk(sclk),
    .sdi(sdi_w), .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl_o(ctrl_o));

  // neighbouring register file model
  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= mem[reg_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_rd_q.size() > 0) begin
      logic [7:0] g, e; string t;
      g = got_q.pop_front(); e = exp_rd_q.pop_front(); t = exp_tag_q.pop_front();
      chk(g == e, t, {8'h0, g}, {8'h0, e});
    end
    if (rst_n && reg_wr) begin
      wr_seen++;
      if (exp_wr_q.size() == 0) chk(0, "R2 unexpected port write", {1'b0, reg_addr, reg_wdata}, 16'h0);
      else begin
        logic [14:0] e;
        e = exp_wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R2 port write", {1'b0, reg_addr, reg_wdata}, {1'b0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] nxt(logic [6:0] l);
    if ((l & 7'h60) == 0) return (l + 7'd1) & 7'h1F;
    return ((l + 7'd1) & 7'h7F) == 0 ? 7'h20 : l + 7'd1;
  endfunction

  function automatic bit rsv(logic [6:0] l);
    return l > 7'h11 && l < 7'h20;
  endfunction

  function automatic logic [7:0] exp_rd(logic [6:0] l);
    if (rsv(l)) return 8'h00;
    if (l == 7'h0F) return exp_ctrl;
    return exp_mem[l];
  endfunction

  task automatic start(input logic s, input logic c);
    cur_spi = s; cur_cpol = c; spi_mode = s;
    sclk = s ? c : 1'b0;
    wait_clk(6);
    ce = 1;
    wait_clk(8);
  endtask

  task automatic stop();
    wait_clk(H);
    ce = 0;
    wait_clk(10);
  endtask

  task automatic xbit(input logic b, output logic r);
    if (cur_spi) begin
      sclk = ~cur_cpol; mosi = b; wait_clk(H);
      r = sdo; sclk = cur_cpol; wait_clk(H);
    end else begin
      mosi = b; wait_clk(H);
      r = sdi_w; sclk = 1; wait_clk(H); sclk = 0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      int k; logic r;
      k = cur_spi ? 7 - i : i;
      xbit(tx[k], r);
      rx[k] = r;
    end
  endtask

  task automatic do_write(input logic s, input logic c, input logic [6:0] a,
                          input logic [7:0] d [4], input int n);
    logic [7:0] rx; logic [6:0] l;
    l = a;
    start(s, c);
    xbyte({1'b1, a}, rx);
    for (int k = 0; k < n; k++) begin
      if (l == 7'h0F) begin
        if (exp_ctrl[6]) exp_ctrl = (exp_ctrl & 8'hBF) | (d[k] & 8'h40);
        else exp_ctrl = d[k] & 8'hC7;
      end else if (!rsv(l) && !exp_ctrl[6]) begin
        exp_wr_q.push_back({l, d[k]});
        exp_mem[l] = d[k];
      end
      xbyte(d[k], rx);
      l = nxt(l);
    end
    stop();
  endtask

  task automatic do_read(input logic s, input logic c, input logic [6:0] a,
                         input int n, input string tag);
    logic [7:0] rx; logic [6:0] l;
    l = a;
    start(s, c);
    xbyte({1'b0, a}, rx);
    chk(sdo_oe == 0, "R5 oe low after address byte", {15'h0, sdo_oe}, 16'h0);
    for (int k = 0; k < n; k++) begin
      exp_rd_q.push_back(exp_rd(l));
      exp_tag_q.push_back(tag);
      xbyte(8'h00, rx);
      got_q.push_back(rx);
      l = nxt(l);
    end
    stop();
    chk(sdo_oe == 0, "R5 oe low after chip enable falls", {15'h0, sdo_oe}, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    int w0;
    logic r;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'((i << 3) - i + 3);
    end
    wait_clk(5);
    // R1
    chk(sdo_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 reset strobes", {13'h0, sdo_oe, reg_wr, reg_rd}, 16'h0);
    chk(ctrl_o == 8'h00, "R1 reset control", {8'h0, ctrl_o}, 16'h0);
    rst_n = 1;
    wait_clk(5);

    // R2 R3 single write and read, idle low
    d = '{8'h37, 8'h0, 8'h0, 8'h0};
    do_write(1, 0, 7'h05, d, 1);
    do_read(1, 0, 7'h05, 1, "R3 R2 idle-low read");
    // R6 R8 read wrap in clock window, idle high
    do_read(1, 1, 7'h1E, 4, "R6 R8 R3 read wrap 1F->00");
    // R7 write wrap 9F->80 with reserved start
    d = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    do_write(1, 1, 7'h1E, d, 4);
    // R7 RAM write wrap FF->A0, then R6 R11 gapless read wrap 7F->20
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(1, 0, 7'h7E, d, 3);
    do_read(1, 0, 7'h7E, 4, "R11 R6 RAM burst read wrap");

    // R4 three-wire link
    d = '{8'hC3, 8'h0, 8'h0, 8'h0};
    do_write(0, 0, 7'h25, d, 1);
    do_read(0, 0, 7'h25, 1, "R4 three-wire read");
    do_read(0, 0, 7'h1F, 3, "R4 R6 three-wire burst wrap");

    // R8 reserved write has no effect
    w0 = wr_seen;
    d = '{8'h55, 8'h0, 8'h0, 8'h0};
    do_write(1, 0, 7'h12, d, 1);
    wait_clk(4);
    chk(wr_seen == w0, "R8 reserved write caused port write", 16'(wr_seen), 16'(w0));
    do_read(1, 0, 7'h12, 1, "R8 reserved read zero");

    // R9 control byte
    d = '{8'hFF, 8'h0, 8'h0, 8'h0};
    do_write(1, 0, 7'h0F, d, 1);
    chk(ctrl_o == 8'hC7, "R9 control masked bits", {8'h0, ctrl_o}, 16'h00C7);
    do_read(1, 1, 7'h0F, 1, "R9 control readback");

    // R10 write protect
    w0 = wr_seen;
    d = '{8'h99, 8'h0, 8'h0, 8'h0};
    do_write(1, 0, 7'h05, d, 1);
    wait_clk(4);
    chk(wr_seen == w0, "R10 protected port write", 16'(wr_seen), 16'(w0));
    d = '{8'h00, 8'h0, 8'h0, 8'h0};
    do_write(0, 0, 7'h0F, d, 1);
    chk(ctrl_o == 8'h87, "R10 only protect bit moves", {8'h0, ctrl_o}, 16'h0087);
    do_read(1, 0, 7'h05, 1, "R10 protected location unchanged");

    // R12 abort mid write byte
    w0 = wr_seen;
    start(1, 0);
    begin
      logic [7:0] rx;
      xbyte(8'h85, rx);
    end
    for (int i = 0; i < 4; i++) xbit(1'b1, r);
    stop();
    wait_clk(4);
    chk(wr_seen == w0, "R12 aborted byte written", 16'(wr_seen), 16'(w0));
    do_read(1, 0, 7'h05, 1, "R12 transaction after abort");

    wait_clk(20);
    chk(exp_wr_q.size() == 0, "R2 missing port writes", 16'(exp_wr_q.size()), 16'h0);
    chk(exp_rd_q.size() == 0, "R2 missing read bytes", 16'(exp_rd_q.size()), 16'h0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule